// File: doc/BRIEF.md
# Sticky-Status Interrupt Collector with Acknowledge-and-Mask Register

This block gathers the event sources of a line-interface device and turns them into one shared interrupt request. It watches a vector of performance-status levels for a change in either direction. It also takes two single-cycle event pulses from an elastic store, one for overflow and one for underflow. Each elastic-store pulse is latched into a sticky status bit. That bit stays set until software reads the status register. Each source has a pending flag. While any pending flag is set, the block drives the shared interrupt line low. The line is open-drain style, so its high level comes from a pull-up outside the block.

A single register does two jobs. It acknowledges interrupts, and it also masks them. Writing 1 to a source's bit masks that source. Once the source's condition has gone away, the same 1 also clears its pending flag. The 1 keeps masking the source until software writes 0 to that bit. The interrupt function works only when the host-mode input is high. When host mode is low, nothing becomes pending and the line is released.

Top module: `lif_irq_ctrl`

## Requirements
- R1: After reset, every acknowledge/mask bit is 0, no interrupt is pending, the status register reads 0 and `irq_pull_low` is 0. A source event straight after reset therefore raises the interrupt.
- R2: In host mode, a change of any `perf_cond` bit, low-to-high or high-to-low, sets that source's pending flag. This applies when the source's mask bit is 0. The flag is set at the clock edge where the input differs from the value sampled at the previous edge. `irq_pull_low` is 1 after that same edge.
- R3: A pulse on `es_ovf_evt` sets `sts_q[0]` and a pulse on `es_unf_evt` sets `sts_q[1]`. This happens whatever the mask or mode. The bit stays 1 until a read.
- R4: When `sts_rd` is high at an edge, both status bits are cleared at that edge. The exception is a bit whose event pulse is high in the same cycle: that bit stays 1.
- R5: In host mode, an overflow or underflow pulse whose mask bit is 0 sets that source's pending flag and drives `irq_pull_low` to 1 after that edge.
- R6: A pending flag whose mask bit is 0 stays set indefinitely, and a status read does not clear it.
- R7: Mask bit mapping: bits `[N_PERF-1:0]` cover `perf_cond`, bit `N_PERF` covers overflow and bit `N_PERF+1` covers underflow. A write takes effect at its edge. A pending flag whose mask bit is 1 clears at the next edge at which its condition is absent. For a performance source, the condition is absent when there is no change in that cycle. For an elastic-store source, the condition is absent when its sticky bit and event pulse are both 0.
- R8: While a mask bit is 1, events on that source never set its pending flag. Writing the bit back to 0 raises no interrupt for events that occurred while it was masked.
- R9: While `host_mode` is 0, `irq_pull_low` is 0 and all pending flags clear at the next edge. Events seen in that mode leave nothing pending after host mode returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_mode | input | 1 | 1 enables the interrupt function |
| perf_cond | input | N_PERF | Performance-status levels watched for change |
| es_ovf_evt | input | 1 | Elastic-store overflow pulse |
| es_unf_evt | input | 1 | Elastic-store underflow pulse |
| ack_wr_en | input | 1 | Write strobe for the acknowledge/mask register |
| ack_wr_data | input | N_PERF+2 | Acknowledge/mask write value |
| sts_rd | input | 1 | Status register read strobe (clear-on-read) |
| sts_q | output | 2 | Sticky status: bit 0 overflow, bit 1 underflow |
| irq_pull_low | output | 1 | 1 pulls the shared interrupt line low |

## Verification
Two functions can act in the same cycle. A status read can land on the same edge as a new elastic-store pulse. A mask write can land while a source's condition is still present. The bench forces the first case by asserting `sts_rd` and `es_ovf_evt` together while only the underflow bit is set. The status register must then read back exactly the overflow bit. For the second case, the bench masks an overflow source while its sticky bit is still set. The interrupt line must stay low until the read removes the condition, and only then be released.

// File: rtl/lif_irq_pkg.sv
// Package: shared constants for the interrupt collector.
// Assumes two elastic-store sources placed above the performance sources.
package lif_irq_pkg;
    localparam int ES_W       = 2;   // number of elastic-store sources
    localparam int ES_OVF_BIT = 0;   // position in the sticky status register
    localparam int ES_UNF_BIT = 1;
endpackage

// File: rtl/lif_irq_edge.sv
// Module: change detector for level status inputs.
// Flags a bit for one cycle when its input differs from the value sampled
// at the previous edge. The first cycle after reset is suppressed so that a
// level already present at reset does not count as a change.
module lif_irq_edge #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] chg_o
);
    logic [W-1:0] prev_q;
    logic         armed_q;

    // Keep the previous sample and arm after the first post-reset cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            armed_q <= 1'b0;
        end else begin
            prev_q  <= lvl_i;
            armed_q <= 1'b1;
        end
    end

    // Difference against the previous sample, gated until armed.
    always_comb chg_o = armed_q ? (lvl_i ^ prev_q) : '0;

    AST_CHG_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_q) |-> (chg_o == '0)); // R2
endmodule

// File: rtl/lif_irq_sticky.sv
// Module: clear-on-read sticky status for the elastic-store events.
// An event pulse sets its bit. A read clears every bit at its edge except a
// bit whose event arrives in that same cycle.
module lif_irq_sticky
    import lif_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ES_W-1:0] evt_i,
    input  logic            rd_i,
    output logic [ES_W-1:0] sts_o
);
    logic [ES_W-1:0] sts_q;

    // Set on event; clear on read, with the event taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= (rd_i ? '0 : sts_q) | evt_i;
    end

    assign sts_o = sts_q;

    genvar g;
    generate
        for (g = 0; g < ES_W; g++) begin : g_chk
            AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (sts_q[g] && !rd_i) |=> sts_q[g]); // R3
            AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_i && !evt_i[g]) |=> !sts_q[g]); // R4
            AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
                evt_i[g] |=> sts_q[g]); // R4
        end
    endgenerate
endmodule

// File: rtl/lif_irq_mask.sv
// Module: acknowledge/mask register.
// A write loads the whole register at its edge. A 1 masks a source and
// acknowledges it; a 0 re-enables it.
module lif_irq_mask #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] mask_o
);
    logic [W-1:0] mask_q;

    // Load on write strobe; reset to all enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_en_i) mask_q <= wr_data_i;
    end

    assign mask_o = mask_q;

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (mask_q == $past(wr_data_i))); // R7
    AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(mask_q)); // R8
endmodule

// File: rtl/lif_irq_pend.sv
// Module: per-source pending flags.
// A flag is set by an unmasked event in host mode. It is cleared only when
// its mask bit is 1 and its condition is absent, or when host mode is off.
// Assumes busy_i covers evt_i (an event counts as a present condition).
module lif_irq_pend #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         host_i,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] busy_i,
    input  logic [N-1:0] mask_i,
    output logic [N-1:0] pend_o
);
    logic [N-1:0] pend_q;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_src
            logic set_w, clr_w;

            // Set and acknowledge terms for this source.
            always_comb begin
                set_w = evt_i[g] && !mask_i[g];
                clr_w = mask_i[g] && !busy_i[g];
            end

            // Pending flag update; host mode off forces clear.
            always_ff @(posedge clk) begin
                if (!rst_n || !host_i) pend_q[g] <= 1'b0;
                else if (set_w)        pend_q[g] <= 1'b1;
                else if (clr_w)        pend_q[g] <= 1'b0;
            end

            AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
                (mask_i[g] && !pend_q[g]) |=> !pend_q[g]); // R8
            AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (host_i && pend_q[g] && !mask_i[g]) |=> pend_q[g]); // R6
            AST_ACK_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
                (host_i && pend_q[g] && busy_i[g]) |=> pend_q[g]); // R7
        end
    endgenerate

    assign pend_o = pend_q;

    AST_HW_MODE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !host_i |=> (pend_q == '0)); // R9
endmodule

// File: rtl/lif_irq_ctrl.sv
// Module: top of the interrupt collector.
// Ties the change detector, sticky status, mask register and pending flags
// together and drives the open-drain style request. Source order in the
// mask register: performance bits low, then overflow, then underflow.
module lif_irq_ctrl
    import lif_irq_pkg::*;
#(
    parameter int N_PERF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_mode,
    input  logic [N_PERF-1:0] perf_cond,
    input  logic              es_ovf_evt,
    input  logic              es_unf_evt,
    input  logic              ack_wr_en,
    input  logic [N_PERF+1:0] ack_wr_data,
    input  logic              sts_rd,
    output logic [1:0]        sts_q,
    output logic              irq_pull_low
);
    localparam int N_SRC = N_PERF + ES_W;

    logic [N_PERF-1:0] perf_chg;
    logic [ES_W-1:0]   es_evt;
    logic [ES_W-1:0]   es_sts;
    logic [N_SRC-1:0]  src_evt;
    logic [N_SRC-1:0]  src_busy;
    logic [N_SRC-1:0]  mask;
    logic [N_SRC-1:0]  pend;

    // Gather the elastic-store pulses in status-bit order.
    always_comb begin
        es_evt             = '0;
        es_evt[ES_OVF_BIT] = es_ovf_evt;
        es_evt[ES_UNF_BIT] = es_unf_evt;
    end

    lif_irq_edge #(.W(N_PERF)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (perf_cond),
        .chg_o (perf_chg)
    );

    lif_irq_sticky u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_i (es_evt),
        .rd_i  (sts_rd),
        .sts_o (es_sts)
    );

    lif_irq_mask #(.W(N_SRC)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (ack_wr_en),
        .wr_data_i (ack_wr_data),
        .mask_o    (mask)
    );

    // Per-source event and condition-present terms.
    always_comb begin
        src_evt  = {es_evt, perf_chg};
        src_busy = {es_evt | es_sts, perf_chg};
    end

    lif_irq_pend #(.N(N_SRC)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .host_i (host_mode),
        .evt_i  (src_evt),
        .busy_i (src_busy),
        .mask_i (mask),
        .pend_o (pend)
    );

    // Pull the shared line low while anything is pending in host mode.
    always_comb begin
        sts_q        = es_sts;
        irq_pull_low = host_mode && (|pend);
    end

    AST_IRQ_RELEASED_HW: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_mode && !$past(host_mode)) |-> !irq_pull_low); // R9
    AST_IRQ_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (host_mode && |(src_evt & ~mask)) |=> (irq_pull_low || !host_mode)); // R2
endmodule

// File: tb/lif_irq_ctrl_tb.sv
module lif_irq_ctrl_tb;
    localparam int NP = 4;
    localparam int NS = NP + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_mode = 1'b1;
    logic [NP-1:0] perf_cond = '0;
    logic          es_ovf_evt = 1'b0;
    logic          es_unf_evt = 1'b0;
    logic          ack_wr_en = 1'b0;
    logic [NS-1:0] ack_wr_data = '0;
    logic          sts_rd = 1'b0;
    logic [1:0]    sts_q;
    logic          irq_pull_low;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    lif_irq_ctrl #(.N_PERF(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .perf_cond(perf_cond),
        .es_ovf_evt(es_ovf_evt), .es_unf_evt(es_unf_evt), .ack_wr_en(ack_wr_en),
        .ack_wr_data(ack_wr_data), .sts_rd(sts_rd), .sts_q(sts_q),
        .irq_pull_low(irq_pull_low)
    );

    task automatic tick(input int n = 1);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr_mask(input logic [NS-1:0] v);
        ack_wr_en = 1'b1; ack_wr_data = v; tick(); ack_wr_en = 1'b0;
    endtask

    task automatic rd_sts();
        sts_rd = 1'b1; tick(); sts_rd = 1'b0;
    endtask

    task automatic pulse(input int src);
        if (src == NP) es_ovf_evt = 1'b1; else es_unf_evt = 1'b1;
        tick();
        es_ovf_evt = 1'b0; es_unf_evt = 1'b0;
    endtask

    // Return to a clean state: acknowledge all, read, re-enable.
    task automatic cleanup();
        wr_mask('1); rd_sts(); tick(2); wr_mask('0);
    endtask

    initial begin
        tick(3); rst_n = 1'b1; tick(2);
        // R1: reset state
        chk("R1 irq", irq_pull_low, 0);
        chk("R1 sts", sts_q, 0);
        perf_cond[0] = 1'b1; tick();
        chk("R1 mask clear after reset", irq_pull_low, 1);
        cleanup();
        chk("R1 released again", irq_pull_low, 0);

        // R2 R3 R5 R7 R8: sweep every source against every mask value
        for (int src = 0; src < NS; src++) begin
            for (int m = 0; m < (1 << NS); m++) begin
                wr_mask(NS'(m));
                if (src < NP) begin
                    perf_cond[src] = ~perf_cond[src]; tick();
                    chk("R2 perf change irq", irq_pull_low, m[src] ? 0 : 1);
                end else begin
                    pulse(src);
                    chk("R5 es event irq", irq_pull_low, m[src] ? 0 : 1);
                    chk("R3 sticky set", sts_q, 1 << (src - NP));
                end
                cleanup();
                chk("R7 ack clears", irq_pull_low, 0);
                tick();
                chk("R8 no late irq after unmask", irq_pull_low, 0);
            end
        end

        // R6: pending holds while unmasked, read does not clear it
        perf_cond[1] = ~perf_cond[1]; tick();
        tick(5); rd_sts(); tick();
        chk("R6 pending holds", irq_pull_low, 1);
        wr_mask(NS'(1 << 1)); tick();
        chk("R7 perf ack", irq_pull_low, 0);
        wr_mask('0);

        // R7: ES ack waits for sticky bit to be read
        pulse(NP);
        chk("R5 ovf irq", irq_pull_low, 1);
        wr_mask(NS'(1 << NP)); tick(3);
        chk("R7 ack waits on sticky", irq_pull_low, 1);
        rd_sts(); tick();
        chk("R7 released after read", irq_pull_low, 0);
        wr_mask('0);

        // R3 R4: sticky hold, read clear, read concurrent with event
        pulse(NP + 1); tick(4);
        chk("R3 unf sticky holds", sts_q, 2);
        sts_rd = 1'b1; es_ovf_evt = 1'b1; tick(); sts_rd = 1'b0; es_ovf_evt = 1'b0;
        chk("R4 read with same-cycle event", sts_q, 1);
        rd_sts();
        chk("R4 plain read clears", sts_q, 0);
        cleanup();

        // R9: hardware mode
        host_mode = 1'b0;
        perf_cond[2] = ~perf_cond[2]; tick();
        chk("R9 released in hw mode", irq_pull_low, 0);
        pulse(NP); tick();
        host_mode = 1'b1; tick(2);
        chk("R9 nothing pending after return", irq_pull_low, 0);
        perf_cond[3] = ~perf_cond[3]; tick();
        chk("R9 pending in host mode", irq_pull_low, 1);
        host_mode = 1'b0; tick();
        chk("R9 drops in hw mode", irq_pull_low, 0);
        host_mode = 1'b1; tick();
        chk("R9 pending cleared by hw mode", irq_pull_low, 0);
        cleanup();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule